// File: doc/BRIEF.md
# Two-Step Conditional Move Unit

This pipelined execution unit performs a conditional move without any operation that reads more than two operands. The move is split into two micro-operations. The first one reads the condition source and the candidate (new) value, runs a zero test on the condition, and stores the boolean outcome as a tag bit placed above the 64-bit candidate. This gives a 65-bit tagged word. The second micro-operation reads the tagged word and the old destination value, and uses the tag to decide which of the two is written out.

At issue, the condition and the new value arrive together. The old destination value arrives on its own port one cycle later, which is when the second micro-operation reads it. A new move may issue on every cycle. Each stage keeps its own valid bit, and the result appears two clocks after issue.

Top module: `cmov_split_unit`

## Requirements
- R1: While `rst_ni` is low, `result_valid_o` is 0 and `result_o` is 0. Reset clears both stage valid bits.
- R2: When `test_op_i` = 0 (equal-to-zero test), the tag is 1 exactly when `cond_i` is all zeros.
- R3: When `test_op_i` = 1 (not-equal-to-zero test), the tag is 1 exactly when `cond_i` has any bit set.
- R4: When the tag is 1, `result_o` equals the `new_i` value sampled at issue.
- R5: When the tag is 0, `result_o` equals the `old_i` value sampled on the clock edge after issue.
- R6: `result_valid_o` is high exactly two rising edges after the edge that samples `issue_valid_i` high.
- R7: Moves issued on consecutive cycles each produce their own correct result, in issue order, one per cycle.
- R8: On any cycle when `result_valid_o` is low, `result_o` keeps the value it had on the previous cycle. `cond_i`, `new_i` and `old_i` have no effect on it then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_valid_i | input | 1 | A move issues this cycle |
| test_op_i | input | 1 | Test kind: 0 = equal to zero, 1 = not equal to zero |
| cond_i | input | 64 | Condition source, sampled at issue |
| new_i | input | 64 | Candidate value, sampled at issue |
| old_i | input | 64 | Old destination value, sampled one cycle after issue |
| result_valid_o | output | 1 | Result valid |
| result_o | output | 64 | Selected value |

## Verification
The assertions assume that `old_i` is the old destination value of the move issued on the previous cycle. They also assume that no issue is attempted while reset is held low, and that control inputs are never X after reset. The bench's driver delays each move's old value by one cycle and presents it on `old_i` alongside the next issue. It holds `issue_valid_i` low throughout reset. The stimulus covers all-zero, single-top-bit and all-ones conditions, both test kinds, unbroken bursts, and gaps. During gaps, it drives garbage onto the data ports to show that the result is held.

// File: rtl/cmov_pkg.sv
package cmov_pkg;
  localparam int unsigned CMOV_DATA_W = 64;

  typedef enum logic {
    TEST_EQZ = 1'b0,
    TEST_NEZ = 1'b1
  } test_op_e;
endpackage

// File: rtl/cmov_tag_stage.sv
// First micro-op: condition + candidate -> tagged word
module cmov_tag_stage #(
  parameter int unsigned DATA_W = cmov_pkg::CMOV_DATA_W,
  localparam int unsigned TAG_W = DATA_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              op_i,
  input  logic [DATA_W-1:0] cond_i,
  input  logic [DATA_W-1:0] cand_i,
  output logic              valid_o,
  output logic [TAG_W-1:0]  word_o
);
  import cmov_pkg::*;

  logic cond_nz;
  logic tag_d;

  assign cond_nz = |cond_i;

  always_comb begin
    unique case (test_op_e'(op_i))
      TEST_EQZ: tag_d = ~cond_nz;
      TEST_NEZ: tag_d = cond_nz;
      default:  tag_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      word_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) word_o <= {tag_d, cand_i};
    end
  end
endmodule

// File: rtl/cmov_select_stage.sv
// Second micro-op: tagged word + old value -> result
module cmov_select_stage #(
  parameter int unsigned DATA_W = cmov_pkg::CMOV_DATA_W,
  localparam int unsigned TAG_W = DATA_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [TAG_W-1:0]  word_i,
  input  logic [DATA_W-1:0] old_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o
);
  logic              tag;
  logic [DATA_W-1:0] cand;

  assign tag  = word_i[TAG_W-1];
  assign cand = word_i[DATA_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) result_o <= tag ? cand : old_i;
    end
  end
endmodule

// File: rtl/cmov_split_unit.sv
module cmov_split_unit #(
  parameter int unsigned DATA_W = cmov_pkg::CMOV_DATA_W,
  localparam int unsigned TAG_W = DATA_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_valid_i,
  input  logic              test_op_i,
  input  logic [DATA_W-1:0] cond_i,
  input  logic [DATA_W-1:0] new_i,
  input  logic [DATA_W-1:0] old_i,
  output logic              result_valid_o,
  output logic [DATA_W-1:0] result_o
);
  logic             s1_valid;
  logic [TAG_W-1:0] s1_word;

  cmov_tag_stage #(.DATA_W(DATA_W)) u_tag (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (issue_valid_i),
    .op_i    (test_op_i),
    .cond_i  (cond_i),
    .cand_i  (new_i),
    .valid_o (s1_valid),
    .word_o  (s1_word)
  );

  cmov_select_stage #(.DATA_W(DATA_W)) u_sel (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (s1_valid),
    .word_i   (s1_word),
    .old_i    (old_i),
    .valid_o  (result_valid_o),
    .result_o (result_o)
  );
endmodule

// File: rtl/cmov_split_unit_chk.sv
module cmov_split_unit_chk #(
  parameter int unsigned DATA_W = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              issue_valid_i,
  input logic              test_op_i,
  input logic [DATA_W-1:0] cond_i,
  input logic [DATA_W-1:0] new_i,
  input logic [DATA_W-1:0] old_i,
  input logic              result_valid_o,
  input logic [DATA_W-1:0] result_o,
  input logic              s1_valid,
  input logic [DATA_W:0]   s1_word
);
  logic [1:0] age;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  // R1
  always_comb begin
    if (!rst_ni) a_reset_r1: assert (!result_valid_o && result_o == '0);
  end

  p_tag_eqz_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_valid_i && !test_op_i) |=> (s1_word[DATA_W] == ($past(cond_i) == '0)));

  p_tag_nez_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_valid_i && test_op_i) |=> (s1_word[DATA_W] == ($past(cond_i) != '0)));

  p_sel_new_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_valid && s1_word[DATA_W]) |=> (result_o == $past(s1_word[DATA_W-1:0])));

  p_sel_old_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_valid && !s1_word[DATA_W]) |=> (result_o == $past(old_i)));

  p_latency_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age >= 2'd2) |-> (result_valid_o == $past(issue_valid_i, 2)));

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age >= 2'd1 && !result_valid_o) |-> $stable(result_o));
endmodule

bind cmov_split_unit cmov_split_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .issue_valid_i  (issue_valid_i),
  .test_op_i      (test_op_i),
  .cond_i         (cond_i),
  .new_i          (new_i),
  .old_i          (old_i),
  .result_valid_o (result_valid_o),
  .result_o       (result_o),
  .s1_valid       (s1_valid),
  .s1_word        (s1_word)
);

// File: tb/cmov_split_unit_tb_top.sv
module cmov_split_unit_tb_top;
  localparam int W = 64;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         issue_valid_i = 1'b0;
  logic         test_op_i = 1'b0;
  logic [W-1:0] cond_i = '0;
  logic [W-1:0] new_i = '0;
  logic [W-1:0] old_i = '0;
  logic         result_valid_o;
  logic [W-1:0] result_o;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  logic [W-1:0] exp_q[$];
  int           cyc_q[$];
  logic [W-1:0] pend_old = '0;
  logic [W-1:0] last_res = '0;

  cmov_split_unit dut_i (.*);

  always #4 clk_i = ~clk_i;  // 125 MHz
  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one cycle of driving; old value of previous issue goes out now
  task automatic step(input bit v, input bit op, input logic [W-1:0] c,
                      input logic [W-1:0] nv, input logic [W-1:0] ov);
    @(negedge clk_i);
    old_i = pend_old;
    issue_valid_i = v;
    test_op_i = op;
    if (v) begin
      cond_i = c;
      new_i = nv;
      pend_old = ov;
      exp_q.push_back((op ? (c != '0) : (c == '0)) ? nv : ov);
      cyc_q.push_back(cyc);
    end else begin
      cond_i = {$urandom, $urandom};
      new_i = {$urandom, $urandom};
      pend_old = {$urandom, $urandom};
    end
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk_i);
      if (rst_ni && !done) begin
        if (result_valid_o) begin
          if (exp_q.size() == 0) begin
            check("R6 unexpected valid", 64'd1, 64'd0);
          end else begin
            logic [W-1:0] e;
            int ic;
            e = exp_q.pop_front();
            ic = cyc_q.pop_front();
            check("R4/R5/R7 result", result_o, e);
            check("R6 latency", 64'(cyc - ic), 64'd2);
          end
        end else begin
          check("R8 hold", result_o, last_res);
        end
        last_res = result_o;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 reset valid", 64'(result_valid_o), 64'd0);
    check("R1 reset data", result_o, 64'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R2: equal-to-zero test
    step(1, 0, 64'd0, 64'hAAAA_0001, 64'hBBBB_0001);
    step(0, 0, 0, 0, 0);
    step(1, 0, 64'd5, 64'hAAAA_0002, 64'hBBBB_0002);
    step(0, 0, 0, 0, 0);
    step(1, 0, 64'h8000_0000_0000_0000, 64'hAAAA_0003, 64'hBBBB_0003);
    // R3: not-equal-to-zero test
    step(1, 1, 64'd0, 64'hCCCC_0001, 64'hDDDD_0001);
    step(1, 1, '1, 64'hCCCC_0002, 64'hDDDD_0002);
    step(1, 1, 64'd1, 64'hCCCC_0003, 64'hDDDD_0003);
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    // R7: back-to-back burst, mixed
    for (int i = 0; i < 300; i++) begin
      logic [W-1:0] c;
      c = ($urandom_range(0, 2) == 0) ? '0 : {$urandom, $urandom};
      step(1, 1'($urandom), c, {$urandom, $urandom}, {$urandom, $urandom});
    end
    // gaps with garbage on data ports (R8)
    for (int i = 0; i < 300; i++) begin
      logic [W-1:0] c;
      c = ($urandom_range(0, 1) == 0) ? '0 : {$urandom, $urandom};
      step(1'($urandom_range(0, 2) == 0), 1'($urandom), c,
           {$urandom, $urandom}, {$urandom, $urandom});
    end
    repeat (4) step(0, 0, 0, 0, 0);
    check("R7 all results drained", 64'(exp_q.size()), 64'd0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule